// File: doc/BRIEF.md
# SPI Serial Memory Command Slave

This block is the serial-bus front end of a small non-volatile memory model. It runs on a fast system clock and samples the SPI pins as ordinary inputs. It finds the rising and falling edges of the serial clock itself. While chip select is low, it shifts an 8-bit instruction in most significant bit first and decodes it into one of six commands.

Memory reads and writes take a 16-bit address after the instruction. Only the low address bits select a byte in the internal 1024-byte array. Reads stream bytes out on the serial output, and the address steps up after each byte. Writes gather bytes in a page buffer and commit them only when chip select rises at a byte boundary.

The block does not hold the write-enable latch, the block protection or the hardware protect logic. A separate status unit owns them. That unit supplies the status byte and two permission inputs, and it receives one-cycle strobes from this block. A hold input pauses a transfer, and the transfer then resumes at the same bit.

Top module: `spi_mem_slave`

## Requirements
- R1: While reset is asserted, spi_so, spi_so_oe, wel_set, wel_clr and sr_wr are all 0.
- R2: Serial input is taken on rising serial-clock edges while chip select is low, most significant bit first. A byte that is the bit-reverse of a valid opcode (for example 0x60) is not decoded as that opcode.
- R3: Opcode 0x06 followed by chip select rising on a byte boundary gives a one-cycle wel_set pulse. Opcode 0x04 gives a one-cycle wel_clr pulse. If chip select rises mid-byte, no pulse is given, and wel_set and wel_clr are never high together.
- R4: Opcode 0x05 shifts the status byte out on spi_so, most significant bit first, with each bit changing after a falling serial-clock edge. The status byte is sampled again at the start of each further byte.
- R5: Opcode 0x03 takes a 16-bit address, of which only the low 10 bits select the byte. It then returns bytes from consecutive addresses, wrapping from 0x3FF to 0x000, until chip select rises.
- R6: Opcode 0x02 takes a 16-bit address and data bytes. When chip select rises on a byte boundary with arr_wr_ok high and at least one byte received, the first PAGE_BYTES bytes are written to consecutive addresses (wrapping at 0x3FF), further bytes are dropped, and wel_clr pulses for one cycle.
- R7: A write that ends with chip select rising mid-byte leaves the array unchanged and gives no strobe.
- R8: Opcode 0x01 followed by at least one data byte and chip select rising on a byte boundary with sr_wr_ok high pulses sr_wr and wel_clr together, with sr_wr_data equal to the first data byte. With sr_wr_ok low, neither pulses.
- R9: An unknown opcode causes no strobe and no output enable until chip select goes high.
- R10: While spi_hold_n is low, serial-clock edges are ignored and spi_so_oe is 0. After release, the transfer continues from the bit where it stopped.
- R11: spi_so_oe is 1 only while chip select is low, hold is inactive, and a status or memory read is in its output phase.
- R12: A write that ends with arr_wr_ok low leaves the array unchanged and gives no wel_clr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_so | output | 1 | Serial data out, 0 when not enabled |
| spi_so_oe | output | 1 | Output enable for spi_so |
| stat_byte | input | 8 | Status byte from the status unit |
| arr_wr_ok | input | 1 | Array write permitted by the status unit |
| sr_wr_ok | input | 1 | Status write permitted by the status unit |
| wel_set | output | 1 | Pulse: set the write-enable latch |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| sr_wr | output | 1 | Pulse: write sr_wr_data into the status register |
| sr_wr_data | output | 8 | Status byte to be written |

## Verification
The strobes wel_set, wel_clr and sr_wr appear in the first system cycle after the clock edge that samples chip select high, and they last exactly one cycle. The bench raises its expectation in the same half-cycle in which it drives chip select, and it compares the expectation after every rising clock edge. spi_so takes each new bit one cycle after the clock edge that samples a falling serial clock, so the bench reads it three cycles later, just before it raises the serial clock. spi_so_oe follows chip select and hold at once and follows the read phase one cycle after the last address or opcode bit is sampled. The per-clock monitor holds to that same alignment.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WE_SET  = 8'h06;
    localparam logic [7:0] OP_WE_CLR  = 8'h04;
    localparam logic [7:0] OP_ST_RD   = 8'h05;
    localparam logic [7:0] OP_ST_WR   = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WE_SET,
        CMD_WE_CLR,
        CMD_ST_RD,
        CMD_ST_WR,
        CMD_MEM_RD,
        CMD_MEM_WR
    } cmd_e;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_ADR,
        PH_DAT,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/spi_mem_decode.sv
module spi_mem_decode
    import spi_mem_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_e       cmd
);

    always_comb begin
        case (opcode)
            OP_WE_SET: cmd = CMD_WE_SET;
            OP_WE_CLR: cmd = CMD_WE_CLR;
            OP_ST_RD:  cmd = CMD_ST_RD;
            OP_ST_WR:  cmd = CMD_ST_WR;
            OP_MEM_RD: cmd = CMD_MEM_RD;
            OP_MEM_WR: cmd = CMD_MEM_WR;
            default:   cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int DEPTH      = 1024,
    parameter int PAGE_BYTES = 16,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = $clog2(PAGE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic [AW-1:0]           base,
    input  logic [CW-1:0]           count,
    input  logic [PAGE_BYTES*8-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [7:0]              rdata
);

    logic [7:0] mem_q [DEPTH];

    // Page commit: each buffered byte lands at base + its slot, wrapping.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (CW'(i) < count) begin
                    mem_q[base + AW'(i)] <= wdata[i*8 +: 8];
                end
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_BITS  = 16,
    parameter int DEPTH      = 1024,
    parameter int PAGE_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_si,
    input  logic       spi_hold_n,
    output logic       spi_so,
    output logic       spi_so_oe,
    input  logic [7:0] stat_byte,
    input  logic       arr_wr_ok,
    input  logic       sr_wr_ok,
    output logic       wel_set,
    output logic       wel_clr,
    output logic       sr_wr,
    output logic [7:0] sr_wr_data
);

    localparam int AW        = $clog2(DEPTH);
    localparam int CW        = $clog2(PAGE_BYTES + 1);
    localparam int ADR_BYTES = ADDR_BITS / 8;
    localparam int ABW       = $clog2(ADR_BYTES) + 1;

    typedef struct packed {
        phase_e                phase;
        cmd_e                  cmd;
        logic [2:0]            bitc;
        logic [7:0]            rx;
        logic [ADDR_BITS-1:0]  adr_sh;
        logic [ABW-1:0]        adr_cnt;
        logic [AW-1:0]         addr;
        logic [AW-1:0]         base;
        logic [CW-1:0]         nbytes;
        logic [7:0]            tx;
        logic                  so;
        logic                  so_en;
        logic                  sck_prev;
        logic                  we_set;
        logic                  we_clr;
        logic                  st_wr;
        logic [7:0]            st_data;
    } st_t;

    st_t                    s_d, s_q;
    logic [PAGE_BYTES*8-1:0] wbuf_d, wbuf_q;

    logic                  rise, fall, byte_done, commit, so_bit;
    logic [7:0]            rx_next;
    logic [ADDR_BITS-1:0]  adr_full;
    logic [AW-1:0]         raddr;
    logic [7:0]            rdata;
    cmd_e                  cmd_new;

    assign rx_next   = {s_q.rx[6:0], spi_si};
    assign adr_full  = {s_q.adr_sh[ADDR_BITS-2:0], spi_si};
    assign rise      = spi_hold_n & ~spi_cs_n & spi_sck & ~s_q.sck_prev;
    assign fall      = spi_hold_n & ~spi_cs_n & ~spi_sck & s_q.sck_prev;
    assign byte_done = rise && (s_q.bitc == 3'd7);
    assign raddr     = (s_q.phase == PH_ADR) ? adr_full[AW-1:0] : s_q.addr;

    spi_mem_decode u_dec (
        .opcode (rx_next),
        .cmd    (cmd_new)
    );

    spi_mem_array #(
        .DEPTH      (DEPTH),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_array (
        .clk    (clk),
        .commit (commit),
        .base   (s_q.base),
        .count  (s_q.nbytes),
        .wdata  (wbuf_q),
        .raddr  (raddr),
        .rdata  (rdata)
    );

    always_comb begin
        s_d          = s_q;
        wbuf_d       = wbuf_q;
        commit       = 1'b0;
        s_d.sck_prev = spi_sck;
        s_d.we_set   = 1'b0;
        s_d.we_clr   = 1'b0;
        s_d.st_wr    = 1'b0;

        if (spi_cs_n) begin
            // End of a transaction: act only on a clean byte boundary.
            if (s_q.phase == PH_DAT && s_q.bitc == 3'd0) begin
                case (s_q.cmd)
                    CMD_WE_SET: s_d.we_set = 1'b1;
                    CMD_WE_CLR: s_d.we_clr = 1'b1;
                    CMD_ST_WR: begin
                        if (s_q.nbytes != '0 && sr_wr_ok) begin
                            s_d.st_wr  = 1'b1;
                            s_d.we_clr = 1'b1;
                        end
                    end
                    CMD_MEM_WR: begin
                        if (s_q.nbytes != '0 && arr_wr_ok) begin
                            commit     = 1'b1;
                            s_d.we_clr = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            s_d.phase   = PH_OPC;
            s_d.cmd     = CMD_NONE;
            s_d.bitc    = 3'd0;
            s_d.adr_cnt = '0;
            s_d.nbytes  = '0;
            s_d.so_en   = 1'b0;
            s_d.so      = 1'b0;
        end else begin
            if (rise) begin
                s_d.rx   = rx_next;
                s_d.bitc = s_q.bitc + 3'd1;
                case (s_q.phase)
                    PH_OPC: begin
                        if (byte_done) begin
                            s_d.cmd = cmd_new;
                            case (cmd_new)
                                CMD_NONE: s_d.phase = PH_SKIP;
                                CMD_ST_RD: begin
                                    s_d.phase = PH_DAT;
                                    s_d.tx    = stat_byte;
                                    s_d.so_en = 1'b1;
                                end
                                CMD_MEM_RD, CMD_MEM_WR: begin
                                    s_d.phase   = PH_ADR;
                                    s_d.adr_cnt = '0;
                                end
                                default: s_d.phase = PH_DAT;
                            endcase
                        end
                    end
                    PH_ADR: begin
                        s_d.adr_sh = adr_full;
                        if (byte_done) begin
                            if (s_q.adr_cnt == ABW'(ADR_BYTES - 1)) begin
                                s_d.phase = PH_DAT;
                                s_d.base  = adr_full[AW-1:0];
                                s_d.addr  = adr_full[AW-1:0];
                                if (s_q.cmd == CMD_MEM_RD) begin
                                    s_d.tx    = rdata;
                                    s_d.addr  = adr_full[AW-1:0] + AW'(1);
                                    s_d.so_en = 1'b1;
                                end
                            end else begin
                                s_d.adr_cnt = s_q.adr_cnt + ABW'(1);
                            end
                        end
                    end
                    PH_DAT: begin
                        if (byte_done) begin
                            case (s_q.cmd)
                                CMD_ST_RD: s_d.tx = stat_byte;
                                CMD_MEM_RD: begin
                                    s_d.tx   = rdata;
                                    s_d.addr = s_q.addr + AW'(1);
                                end
                                CMD_ST_WR: begin
                                    if (s_q.nbytes == '0) begin
                                        s_d.st_data = rx_next;
                                        s_d.nbytes  = CW'(1);
                                    end
                                end
                                CMD_MEM_WR: begin
                                    if (s_q.nbytes < CW'(PAGE_BYTES)) begin
                                        for (int i = 0; i < PAGE_BYTES; i++) begin
                                            if (s_q.nbytes == CW'(i)) begin
                                                wbuf_d[i*8 +: 8] = rx_next;
                                            end
                                        end
                                        s_d.nbytes = s_q.nbytes + CW'(1);
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
            if (fall && s_q.so_en) begin
                s_d.so = s_q.tx[7];
                s_d.tx = {s_q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            wbuf_q <= '0;
        end else begin
            s_q    <= s_d;
            wbuf_q <= wbuf_d;
        end
    end

    assign so_bit     = s_q.so;
    assign spi_so_oe  = s_q.so_en & ~spi_cs_n & spi_hold_n;
    assign spi_so     = spi_so_oe & s_q.so;
    assign wel_set    = s_q.we_set;
    assign wel_clr    = s_q.we_clr;
    assign sr_wr      = s_q.st_wr;
    assign sr_wr_data = s_q.st_data;

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_hold_n,
    input logic spi_so_oe,
    input logic wel_set,
    input logic wel_clr,
    input logic sr_wr,
    input logic so_bit,
    input logic commit
);

    // R3
    we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wel_set && wel_clr));

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_set |=> !wel_set);

    // R6
    strobe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set || wel_clr || sr_wr) |-> $past(spi_cs_n));

    // R7
    commit_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> spi_cs_n);

    // R8
    sr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |-> wel_clr);

    // R10
    hold_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_hold_n |-> !spi_so_oe);

    // R10
    hold_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_hold_n && !spi_cs_n) |=> $stable(so_bit));

endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_hold_n (spi_hold_n),
    .spi_so_oe  (spi_so_oe),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .sr_wr      (sr_wr),
    .so_bit     (so_bit),
    .commit     (commit)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

    localparam int PAGE = 16;
    localparam int DEP  = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0, spi_hold_n = 1'b1;
    logic       spi_so, spi_so_oe;
    logic [7:0] stat_byte = 8'h00;
    logic       arr_wr_ok = 1'b1, sr_wr_ok = 1'b1;
    logic       wel_set, wel_clr, sr_wr;
    logic [7:0] sr_wr_data;

    int vec = 0, fails = 0;
    logic mon_on = 1'b0;
    logic exp_ws = 0, exp_wc = 0, exp_sw = 0, exp_oe = 0;
    logic [7:0] exp_sd = 8'h00;

    logic [7:0] mem_m [DEP];
    bit         known_m [DEP];

    always #2 clk = ~clk;

    spi_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
        .spi_so_oe(spi_so_oe), .stat_byte(stat_byte), .arr_wr_ok(arr_wr_ok),
        .sr_wr_ok(sr_wr_ok), .wel_set(wel_set), .wel_clr(wel_clr),
        .sr_wr(sr_wr), .sr_wr_data(sr_wr_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vec++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    endtask

    // Per-clock comparison of strobes and output enable against the model.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            chk("R3", "wel_set", int'(wel_set), int'(exp_ws));
            chk("R6", "wel_clr", int'(wel_clr), int'(exp_wc));
            chk("R8", "sr_wr", int'(sr_wr), int'(exp_sw));
            if (exp_sw) chk("R8", "sr_wr_data", int'(sr_wr_data), int'(exp_sd));
            chk("R11", "spi_so_oe", int'(spi_so_oe), int'(exp_oe));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic spi_begin();
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic spi_end(input bit ws, input bit wc, input bit sw, input logic [7:0] sd);
        @(negedge clk); spi_sck = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk);
        spi_cs_n = 1'b1; exp_oe = 0;
        exp_ws = ws; exp_wc = wc; exp_sw = sw; exp_sd = sd;
        @(negedge clk);
        exp_ws = 0; exp_wc = 0; exp_sw = 0;
        repeat (2) @(negedge clk);
    endtask

    // Send the top nbits of tx; return what was on spi_so before each rising edge.
    task automatic xfer(input logic [7:0] tx, input int nbits, input bit load,
                        input int hold_at, output logic [7:0] rx);
        logic saved;
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (i == hold_at) begin
                @(negedge clk);
                saved = exp_oe; spi_hold_n = 1'b0; exp_oe = 0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); spi_sck = 1'b0; spi_si = ~spi_si;
                    repeat (2) @(negedge clk); spi_sck = 1'b1;
                    repeat (2) @(negedge clk);
                end
                @(negedge clk); spi_hold_n = 1'b1; exp_oe = saved;
            end
            @(negedge clk); spi_si = tx[i]; spi_sck = 1'b0;
            repeat (3) @(negedge clk);
            rx[i] = spi_so;
            @(negedge clk); spi_sck = 1'b1;
            if (i == 0 && load) exp_oe = 1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_read(input int a, input int n, input int hold_at, input string req);
        logic [7:0] r;
        int idx;
        spi_begin();
        xfer(8'h03, 8, 0, -1, r);
        xfer(a[15:8], 8, 0, -1, r);
        xfer(a[7:0], 8, 1, -1, r);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, 0, (i == 0) ? hold_at : -1, r);
            idx = (a + i) % DEP;
            if (known_m[idx]) chk(req, $sformatf("read byte %0d", i), int'(r), int'(mem_m[idx]));
        end
        spi_end(0, 0, 0, 8'h00);
    endtask

    task automatic do_write(input int a, input int n, input logic [7:0] d0,
                            input bit ok, input int part);
        logic [7:0] r;
        bit done;
        arr_wr_ok = ok;
        spi_begin();
        xfer(8'h02, 8, 0, -1, r);
        xfer(a[15:8], 8, 0, -1, r);
        xfer(a[7:0], 8, 0, -1, r);
        for (int i = 0; i < n; i++) xfer(d0 + 8'(i), 8, 0, -1, r);
        if (part > 0) xfer(8'h99, part, 0, -1, r);
        done = ok && (n > 0) && (part == 0);
        spi_end(0, done, 0, 8'h00);
        if (done) begin
            for (int i = 0; i < n && i < PAGE; i++) begin
                mem_m[(a + i) % DEP]   = d0 + 8'(i);
                known_m[(a + i) % DEP] = 1;
            end
        end
        arr_wr_ok = 1'b1;
    endtask

    initial begin
        logic [7:0] r, r2;
        for (int i = 0; i < DEP; i++) known_m[i] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "reset outputs", int'({spi_so, spi_so_oe, wel_set, wel_clr, sr_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk); mon_on = 1'b1;

        // R3: set and clear opcodes
        spi_begin(); xfer(8'h06, 8, 0, -1, r); spi_end(1, 0, 0, 8'h00);
        spi_begin(); xfer(8'h04, 8, 0, -1, r); spi_end(0, 1, 0, 8'h00);
        // R3: extra partial bits, no pulse
        spi_begin(); xfer(8'h06, 8, 0, -1, r); xfer(8'h00, 3, 0, -1, r); spi_end(0, 0, 0, 8'h00);
        // R2: bit-reversed set opcode is not decoded
        spi_begin(); xfer(8'h60, 8, 0, -1, r); spi_end(0, 0, 0, 8'h00);

        // R4: status read, status sampled again per byte
        stat_byte = 8'hA5;
        spi_begin(); xfer(8'h05, 8, 1, -1, r);
        stat_byte = 8'h3C;
        xfer(8'h00, 8, 0, -1, r); xfer(8'h00, 8, 0, -1, r2);
        spi_end(0, 0, 0, 8'h00);
        chk("R4", "status byte 0", int'(r), 8'hA5);
        chk("R4", "status byte 1", int'(r2), 8'h3C);

        // R6 / R5
        do_write(16'h0010, 3, 8'h11, 1, 0);
        do_read(16'h0010, 3, -1, "R5");
        // R5: high address bits ignored and wrap at the top
        do_write(16'hFFFF, 2, 8'h5A, 1, 0);
        do_read(16'h03FF, 2, -1, "R5");
        do_read(16'hA7FF, 2, -1, "R5");

        // R7: aborted mid-byte, array unchanged
        do_write(16'h0010, 1, 8'h99, 1, 4);
        do_read(16'h0010, 1, -1, "R7");
        // R12: permission withheld
        do_write(16'h0011, 2, 8'hF0, 0, 0);
        do_read(16'h0011, 2, -1, "R12");

        // R8: status write, first byte used; then refused
        sr_wr_ok = 1'b1;
        spi_begin(); xfer(8'h01, 8, 0, -1, r); xfer(8'h81, 8, 0, -1, r); xfer(8'h7E, 8, 0, -1, r);
        spi_end(0, 1, 1, 8'h81);
        sr_wr_ok = 1'b0;
        spi_begin(); xfer(8'h01, 8, 0, -1, r); xfer(8'h8C, 8, 0, -1, r);
        spi_end(0, 0, 0, 8'h00);
        sr_wr_ok = 1'b1;

        // R9: unknown opcode, SO silent
        spi_begin(); xfer(8'h0B, 8, 0, -1, r); xfer(8'hFF, 8, 0, -1, r); xfer(8'h00, 8, 0, -1, r);
        spi_end(0, 0, 0, 8'h00);
        chk("R9", "spi_so after unknown opcode", int'(r), 0);

        // R10: hold in the middle of a read byte
        do_read(16'h0010, 2, 3, "R10");

        // R6: page overflow keeps only PAGE bytes
        do_write(16'h0100 + PAGE, 2, 8'hEE, 1, 0);
        do_write(16'h0100, PAGE + 2, 8'h40, 1, 0);
        do_read(16'h0100, PAGE + 2, -1, "R6");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule